// File: doc/BRIEF.md
# Zero-Register General-Purpose Register File

This block is the architectural register store of a small single-cycle RISC core. It holds 32 words of 32 bits each. A single write port accepts an index, a data word and an enable. Two read ports, each with its own index, return the addressed words combinationally. The core's decoder drives the two read indices from the source-operand fields of the instruction. The write-back stage drives the write port with the destination index and the result.

Entry zero is a constant. It always reads as zero, and any write aimed at it is thrown away, so software can use it as a zero source and as a discard target. Writes commit on the falling clock edge. The result of an operation therefore lands halfway through the cycle, and a read made in the second half of that cycle already returns it.

A synchronous, active-high reset, sampled on the same falling edge as writes, clears every entry to zero.

Top module: `zreg_regfile`

## Requirements
- R1: The file stores 32 independent 32-bit words, selected by a 5-bit index. A write to index k with enable high is later returned by a read of index k. Other entries are left untouched.
- R2: A read of index 0 on either port returns 32'h0000_0000 at all times.
- R3: A write to index 0 with the enable high has no effect. Index 0 still reads zero, and no other entry changes.
- R4: While the write enable is low, no entry changes on any clock edge, whatever the write index and write data are.
- R5: A write is committed on the falling clock edge. Between the rising edge and the falling edge, a read of the target index still returns the old value. After the falling edge, it returns the new value.
- R6: The two read ports are combinational and independent. Each output follows its own index with no clock latency.
- R7: When both read indices are equal, both outputs carry the same value.
- R8: When reset is high at a falling clock edge, every entry reads zero afterwards. Reset takes priority over a simultaneous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Destination entry index |
| wr_data | input | 32 | Word to store |
| rd_idx_a | input | 5 | Index for read port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_a | output | 32 | Word at rd_idx_a |
| rd_data_b | output | 32 | Word at rd_idx_b |

## Verification
A write and a read of the same entry can happen in the same cycle. The read must return the old word before the falling edge and the new word after it. The bench provokes this by setting a read port to the write target. It samples the port once between the rising and falling edges and once after the falling edge, and compares both samples with a reference array that is updated only at the falling edge. The bench also sweeps every pair of read indices across the full file, writes to index 0 and with the enable low, and applies a long pseudo-random mix of writes and reads. Each read is judged against the reference array.

// File: rtl/zreg_regfile_pkg.sv
package zreg_regfile_pkg;

    parameter int RF_ADDR_W = 5;
    parameter int RF_DATA_W = 32;
    localparam int RF_DEPTH = 1 << RF_ADDR_W;

    typedef logic [RF_ADDR_W-1:0] idx_t;
    typedef logic [RF_DATA_W-1:0] word_t;
    typedef logic [RF_DEPTH-1:0]  sel_t;
    typedef word_t [RF_DEPTH-1:0] bank_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    function automatic logic is_zero_idx(idx_t idx);
        return idx == '0;
    endfunction

endpackage

// File: rtl/zreg_wr_decode.sv
module zreg_wr_decode
    import zreg_regfile_pkg::*;
(
    input  wr_req_t req_i,
    output sel_t    sel_o
);

    // One select line per entry; line 0 is never raised.
    for (genvar e = 0; e < RF_DEPTH; e++) begin : g_sel
        if (e == 0) begin : g_zero
            assign sel_o[e] = 1'b0;
        end else begin : g_live
            assign sel_o[e] = req_i.en && !is_zero_idx(req_i.idx)
                              && (req_i.idx == idx_t'(e));
        end
    end

endmodule

// File: rtl/zreg_bank.sv
module zreg_bank
    import zreg_regfile_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req_i,
    input  sel_t    sel_i,
    output bank_t   bank_o
);

    for (genvar e = 0; e < RF_DEPTH; e++) begin : g_ent
        if (e == 0) begin : g_const
            assign bank_o[e] = '0;
        end else begin : g_reg
            word_t q;
            always_ff @(negedge clk) begin
                if (rst)
                    q <= '0;
                else if (sel_i[e])
                    q <= req_i.data;
            end
            assign bank_o[e] = q;
        end
    end

    // R1
    sel_single_chk: assert property (@(negedge clk) disable iff (rst)
        $onehot0(sel_i));

    // R4
    hold_when_idle_chk: assert property (@(negedge clk) disable iff (rst)
        !req_i.en |=> $stable(bank_o));

    // R5
    write_lands_chk: assert property (@(negedge clk) disable iff (rst)
        (req_i.en && !is_zero_idx(req_i.idx))
        |=> bank_o[$past(req_i.idx)] == $past(req_i.data));

    // R3
    zero_write_drop_chk: assert property (@(negedge clk) disable iff (rst)
        (req_i.en && is_zero_idx(req_i.idx)) |=> $stable(bank_o));

endmodule

// File: rtl/zreg_rd_port.sv
module zreg_rd_port
    import zreg_regfile_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  bank_t bank_i,
    input  idx_t  idx_i,
    output word_t data_o
);

    always_comb data_o = bank_i[idx_i];

    // R2
    zero_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        is_zero_idx(idx_i) |-> (data_o == '0));

endmodule

// File: rtl/zreg_regfile.sv
module zreg_regfile
    import zreg_regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic [4:0]  rd_idx_a,
    input  logic [4:0]  rd_idx_b,
    output logic [31:0] rd_data_a,
    output logic [31:0] rd_data_b
);

    localparam int NUM_RD = 2;

    wr_req_t req;
    sel_t    sel;
    bank_t   bank;
    idx_t    rd_idx [NUM_RD];
    word_t   rd_data [NUM_RD];

    assign req = '{en: wr_en, idx: wr_idx, data: wr_data};
    assign rd_idx[0] = rd_idx_a;
    assign rd_idx[1] = rd_idx_b;
    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    zreg_wr_decode u_dec (
        .req_i (req),
        .sel_o (sel)
    );

    zreg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .sel_i  (sel),
        .bank_o (bank)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        zreg_rd_port u_port (
            .clk    (clk),
            .rst    (rst),
            .bank_i (bank),
            .idx_i  (rd_idx[p]),
            .data_o (rd_data[p])
        );
    end

    // R7
    same_idx_same_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));

endmodule

// File: tb/sim_zreg_regfile.sv
`timescale 1ns/100ps
module sim_zreg_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx_a = '0;
    logic [4:0]  rd_idx_b = '0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;

    logic [31:0] model [32];
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    zreg_regfile u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // Read both ports and compare against the model (R6, R7 combinational).
    task automatic read_pair(input logic [4:0] a, input logic [4:0] b,
                             input string req);
        rd_idx_a = a;
        rd_idx_b = b;
        #0.1;
        check(req, rd_data_a, model[a]);
        check(req, rd_data_b, model[b]);
    endtask

    // One write cycle; port A watches the target before and after the falling edge.
    task automatic write_cycle(input logic en, input logic [4:0] idx,
                               input logic [31:0] data, input string req);
        @(posedge clk);
        #0.5;
        wr_en = en;
        wr_idx = idx;
        wr_data = data;
        rd_idx_a = idx;
        #0.5;
        check({req, " R5 before fall"}, rd_data_a, model[idx]);
        @(negedge clk);
        if (en && idx != 5'd0) model[idx] = data;
        #0.5;
        check({req, " R5 after fall"}, rd_data_a, model[idx]);
        @(posedge clk);
        #0.5;
        wr_en = 1'b0;
    endtask

    task automatic sweep_all(input string req);
        for (int a = 0; a < 32; a++)
            for (int b = 0; b < 32; b++)
                read_pair(a[4:0], b[4:0], req);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        // Reset state: cleared on falling edges with rst high (R8)
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        for (int i = 0; i < 32; i++) read_pair(i[4:0], 5'd31 - i[4:0], "R8 reset clear");

        // Fill every entry, including index 0 (R1, R3)
        for (int i = 0; i < 32; i++)
            write_cycle(1'b1, i[4:0], 32'hC3A5_0000 ^ (i * 32'h0101_0107) ^ 32'hFFFF,
                        "R1 fill");
        sweep_all("R1 R2 R6 R7 sweep");

        // Enable low with varied indices and data (R4)
        for (int i = 0; i < 32; i++)
            write_cycle(1'b0, i[4:0], ~(i * 32'h1357_9BDF), "R4 enable low");
        sweep_all("R4 hold sweep");

        // Repeated writes to entry zero (R3, R2)
        write_cycle(1'b1, 5'd0, 32'hFFFF_FFFF, "R3 zero write");
        write_cycle(1'b1, 5'd0, 32'h8000_0001, "R3 zero write");
        read_pair(5'd0, 5'd0, "R2 zero both ports");
        sweep_all("R3 others intact");

        // Pseudo-random mix of writes and reads
        for (int k = 0; k < 1500; k++) begin
            step_lfsr();
            write_cycle(lfsr[7], lfsr[4:0], lfsr ^ 32'h5A5A_0F0F, "R1 R5 random write");
            step_lfsr();
            read_pair(lfsr[4:0], lfsr[12:8], "R6 random read");
            read_pair(lfsr[20:16], lfsr[20:16], "R7 same index");
        end

        // Reset wins over a simultaneous write (R8)
        @(posedge clk);
        #0.5;
        rst = 1'b1;
        wr_en = 1'b1;
        wr_idx = 5'd9;
        wr_data = 32'hDEAD_0009;
        @(negedge clk);
        #0.5;
        for (int i = 0; i < 32; i++) model[i] = '0;
        rd_idx_a = 5'd9;
        #0.1;
        check("R8 reset over write", rd_data_a, 32'h0);
        @(posedge clk);
        #0.5;
        rst = 1'b0;
        wr_en = 1'b0;
        sweep_all("R8 cleared sweep");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule